// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer that sits on a simple register port. A 16-bit up-counter advances on a prescaled clock. The prescaler divisor is one of eight settings. When the counter passes its top value, the block raises a one-cycle reset request toward the system reset controller. Software keeps the system alive by loading a fresh start value into the counter before it wraps. A load of 65536 minus N leaves N prescaled ticks before the timeout. Reading the counter at any time gives the elapsed part of the window.

Each of the three registers is guarded by a key in the upper bits of the write data. A write whose key is wrong is dropped without effect, so a stray store cannot stop or starve the watchdog. A counter load takes a few prescaled ticks to settle, and a read-only busy flag in the control register shows this. While the flag is set, the counter is frozen and further loads are refused.

The overflow flag is held on the power-on reset only. It therefore survives the system reset that the watchdog itself provokes. After restart, software can read it to tell that the last reset came from a timeout.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset the counter (offset 0x0), the control register (offset 0x4) and the auxiliary register (offset 0x8) all read 0, and `rst_req` is low.
- R2: A write to offset 0x0 loads bits 15:0 into the counter only when bits 31:16 equal 0x5A5A. Any other key leaves the counter unchanged.
- R3: A write to offset 0x4 or 0x8 takes effect only when bits 31:8 equal 0xA5A5A5, with the data in bits 7:0. A write with any other key, including the counter key, changes nothing.
- R4: While control bit 7 (enable) is set and the busy flag is clear, the counter advances by one on every prescaled tick. Offset 0x0 reads back its present value in bits 15:0.
- R5: Control bits 2:0 select the number of clock cycles per prescaled tick. Codes 0 to 7 give 1, 4, 16, 32, 64, 128, 1024 and 4096 cycles.
- R6: While enable is clear, the counter holds its value. Writing enable to 0 stops the watchdog.
- R7: Control bit 5 (busy) reads 1 from the cycle after an accepted counter load. It stays at 1 for two prescaled ticks, and the counter does not advance meanwhile. A control write cannot change it.
- R8: A counter write that arrives while busy is set is ignored.
- R9: A tick with enable set and the counter at 0xFFFF wraps the counter to 0, sets control bit 4 (overflow) and clears enable. In the next cycle `rst_req` is high for exactly one cycle.
- R10: The overflow flag keeps its value through `sys_rst_n`, which clears everything else. It is cleared only by an accepted control write with bit 4 at 0, or by `por_n`.
- R11: An accepted counter load on the same edge as an overflowing tick wins. The counter takes the loaded value, and no overflow is flagged or requested.
- R12: The auxiliary register stores the 8 data bits of an accepted write and reads them back in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counter |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | System reset, active low, clears all state except the overflow flag |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, key in the upper bits |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two functions can coincide on a single edge: a keep-alive reload and the overflow it is meant to prevent. The bench starts the counter three ticks below the wrap with the divide-by-1 setting. It confirms that the counter reads 0xFFFF one cycle ahead, then lands a keyed load on exactly the wrapping edge. The result is judged by the loaded value appearing in the counter with busy set, and by the overflow flag and `rst_req` both staying low. A control run from the same start without the load fixes the expected overflow cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // register offsets (byte addresses)
   localparam logic [3:0] OFS_COUNT = 4'h0;
   localparam logic [3:0] OFS_CTRL  = 4'h4;
   localparam logic [3:0] OFS_AUX   = 4'h8;

   // write keys
   localparam logic [15:0] KEY_COUNT = 16'h5A5A;
   localparam logic [23:0] KEY_CTRL  = 24'hA5A5A5;

   // control register bit positions
   localparam int CTRL_EN_BIT   = 7;
   localparam int CTRL_BUSY_BIT = 5;
   localparam int CTRL_OVF_BIT  = 4;

   // largest prescaler shift (divide by 4096)
   localparam int MAX_DIV_SHIFT = 12;

   typedef struct packed {
      logic cnt_wr;
      logic ctrl_wr;
      logic aux_wr;
   } wr_strobe_t;

   // log2 of the divisor for each select code
   function automatic int div_shift(input logic [2:0] code);
      case (code)
         3'd0:    return 0;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 5;
         3'd4:    return 6;
         3'd5:    return 7;
         3'd6:    return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
   import kwdt_pkg::*;
#(
   parameter int PRESC_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] div_sel,
   output logic       tick
);

   generate
      if (PRESC_W < MAX_DIV_SHIFT) begin : g_bad_width
         $error("kwdt_prescaler: PRESC_W too small for the largest divisor");
      end
   endgenerate

   logic [PRESC_W-1:0] presc_q;
   logic [PRESC_W-1:0] mask;

   // low bits that must all be one for a tick
   always_comb begin
      mask = '0;
      for (int i = 0; i < PRESC_W; i++) begin
         mask[i] = (i < div_shift(div_sel));
      end
   end

   assign tick = ((presc_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
      end else begin
         presc_q <= presc_q + 1'b1;
      end
   end

endmodule

// File: rtl/kwdt_regif.sv
module kwdt_regif
   import kwdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [3:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output wr_strobe_t       strobe,
   output logic [CNT_W-1:0] cnt_data,
   output logic             ctrl_en_data,
   output logic             ctrl_ovf_data,
   output logic [2:0]       div_sel,
   input  logic [CNT_W-1:0] count_i,
   input  logic             en_i,
   input  logic             busy_i,
   input  logic             ovf_i
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("kwdt_regif: CNT_W must lie between 2 and 16");
      end
   endgenerate

   localparam int PAD_W = 32 - CNT_W;

   logic       cnt_key_ok;
   logic       ctrl_key_ok;
   logic [7:0] aux_q;
   logic [7:0] ctrl_view;

   assign cnt_key_ok  = (bus_wdata[31:16] == KEY_COUNT);
   assign ctrl_key_ok = (bus_wdata[31:8] == KEY_CTRL);

   always_comb begin
      strobe.cnt_wr  = bus_wr && (bus_addr == OFS_COUNT) && cnt_key_ok;
      strobe.ctrl_wr = bus_wr && (bus_addr == OFS_CTRL) && ctrl_key_ok;
      strobe.aux_wr  = bus_wr && (bus_addr == OFS_AUX) && ctrl_key_ok;
   end

   assign cnt_data      = bus_wdata[CNT_W-1:0];
   assign ctrl_en_data  = bus_wdata[CTRL_EN_BIT];
   assign ctrl_ovf_data = bus_wdata[CTRL_OVF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_sel <= '0;
         aux_q   <= '0;
      end else begin
         if (strobe.ctrl_wr) div_sel <= bus_wdata[2:0];
         if (strobe.aux_wr)  aux_q   <= bus_wdata[7:0];
      end
   end

   always_comb begin
      ctrl_view                = '0;
      ctrl_view[2:0]           = div_sel;
      ctrl_view[CTRL_OVF_BIT]  = ovf_i;
      ctrl_view[CTRL_BUSY_BIT] = busy_i;
      ctrl_view[CTRL_EN_BIT]   = en_i;
   end

   always_comb begin
      case (bus_addr)
         OFS_COUNT: bus_rdata = {{PAD_W{1'b0}}, count_i};
         OFS_CTRL:  bus_rdata = {24'h0, ctrl_view};
         OFS_AUX:   bus_rdata = {24'h0, aux_q};
         default:   bus_rdata = '0;
      endcase
   end

   // R3: a wrong key leaves the auxiliary register untouched
   assert_aux_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_AUX && !ctrl_key_ok) |=> $stable(aux_q));

   // R3: a wrong key leaves the divisor select untouched
   assert_ctrl_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CTRL && !ctrl_key_ok) |=> $stable(div_sel));

endmodule

// File: rtl/kwdt_count_core.sv
module kwdt_count_core
#(
   parameter int CNT_W      = 16,
   parameter int SYNC_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_data,
   input  logic             ctrl_wr,
   input  logic             ctrl_en_data,
   input  logic             ctrl_ovf_data,
   output logic [CNT_W-1:0] count_o,
   output logic             en_o,
   output logic             busy_o,
   output logic             ovf_o,
   output logic             rst_req_o
);

   generate
      if (SYNC_TICKS < 0 || SYNC_TICKS > 255) begin : g_bad_sync
         $error("kwdt_count_core: SYNC_TICKS out of range");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic             en_q;
   logic             ovf_q;
   logic             rst_req_q;
   logic             busy;
   logic             load;
   logic             run;
   logic             ovf_evt;

   assign load    = cnt_wr && !busy;
   assign run     = tick && en_q && !busy;
   assign ovf_evt = run && (&count_q) && !load;

   // load settling window, counted in prescaled ticks
   generate
      if (SYNC_TICKS == 0) begin : g_no_sync
         assign busy = 1'b0;
      end else begin : g_sync
         localparam int SW = $clog2(SYNC_TICKS + 1);
         logic [SW-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else if (load) begin
               sync_q <= SW'(SYNC_TICKS);
            end else if (tick && sync_q != '0) begin
               sync_q <= sync_q - 1'b1;
            end
         end
         assign busy = (sync_q != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         en_q      <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= ovf_evt;
         if (load) begin
            count_q <= cnt_data;
         end else if (run) begin
            count_q <= count_q + 1'b1;
         end
         if (ovf_evt) begin
            en_q <= 1'b0;
         end else if (ctrl_wr) begin
            en_q <= ctrl_en_data;
         end
      end
   end

   // sticky flag: only the power-on reset clears it asynchronously
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ovf_q <= 1'b0;
      end else if (ovf_evt) begin
         ovf_q <= 1'b1;
      end else if (ctrl_wr && !ctrl_ovf_data) begin
         ovf_q <= 1'b0;
      end
   end

   assign count_o   = count_q;
   assign en_o      = en_q;
   assign busy_o    = busy;
   assign ovf_o     = ovf_q;
   assign rst_req_o = rst_req_q;

   // R6: with enable clear and no load, the counter holds
   assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cnt_wr) |=> $stable(count_q));

   // R7: while busy, the counter neither counts nor loads
   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(count_q));

   // R9: reset request lasts a single cycle
   assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |=> !rst_req_q);

   // R9: a request comes with the flag set, enable off and the counter at zero
   assert_req_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |-> (ovf_q && !en_q && count_q == '0));

   // R10: the flag falls only after a clearing control write
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
      $fell(ovf_q) |-> $past(ctrl_wr && !ctrl_ovf_data));

   // R11: an accepted load wins over a coinciding overflow
   assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !busy) |=> (count_q == $past(cnt_data) && !rst_req_q));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import kwdt_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int PRESC_W    = 12,
   parameter int SYNC_TICKS = 2
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        sys_rst_n,
   input  logic        bus_wr,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        rst_req
);

   logic             rst_n;
   wr_strobe_t       strobe;
   logic [CNT_W-1:0] cnt_data;
   logic             ctrl_en_data;
   logic             ctrl_ovf_data;
   logic [2:0]       div_sel;
   logic             tick;
   logic [CNT_W-1:0] count;
   logic             en;
   logic             busy;
   logic             ovf;

   assign rst_n = por_n & sys_rst_n;

   kwdt_regif #(.CNT_W(CNT_W)) regif_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_wr        (bus_wr),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .strobe        (strobe),
      .cnt_data      (cnt_data),
      .ctrl_en_data  (ctrl_en_data),
      .ctrl_ovf_data (ctrl_ovf_data),
      .div_sel       (div_sel),
      .count_i       (count),
      .en_i          (en),
      .busy_i        (busy),
      .ovf_i         (ovf)
   );

   kwdt_prescaler #(.PRESC_W(PRESC_W)) presc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .tick    (tick)
   );

   kwdt_count_core #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) core_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .por_n         (por_n),
      .tick          (tick),
      .cnt_wr        (strobe.cnt_wr),
      .cnt_data      (cnt_data),
      .ctrl_wr       (strobe.ctrl_wr),
      .ctrl_en_data  (ctrl_en_data),
      .ctrl_ovf_data (ctrl_ovf_data),
      .count_o       (count),
      .en_o          (en),
      .busy_o        (busy),
      .ovf_o         (ovf),
      .rst_req_o     (rst_req)
   );

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   localparam logic [3:0] A_CNT  = 4'h0;
   localparam logic [3:0] A_CTRL = 4'h4;
   localparam logic [3:0] A_AUX  = 4'h8;
   localparam logic [31:0] K_CNT  = 32'h5A5A_0000;
   localparam logic [31:0] K_CTRL = 32'hA5A5_A500;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   keyed_wdt dut_i (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rst_req   (rst_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG_CYCLES && !done) begin
         done = 1'b1;
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WATCHDOG_CYCLES);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge; sampled at the edge between
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(A_CTRL, v);
         if (!v[5]) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_CNT, v);  chk("R1 counter", v, 32'h0);
      rd(A_CTRL, v); chk("R1 control", v, 32'h0);
      rd(A_AUX, v);  chk("R1 aux", v, 32'h0);
      chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
   endtask

   task automatic t_keys();
      logic [31:0] v;
      wr(A_CNT, K_CNT | 32'h0042);
      rd(A_CNT, v); chk("R2 keyed load", v, 32'h0042);
      wait_idle();
      wr(A_CNT, 32'h5A5B_0077);
      rd(A_CNT, v); chk("R2 wrong key ignored", v, 32'h0042);
      wr(A_CTRL, 32'h5A5A_0081);
      rd(A_CTRL, v); chk("R3 counter key on control ignored", v, 32'h0);
      wr(A_CTRL, 32'hA5A5_A481);
      rd(A_CTRL, v); chk("R3 wrong control key ignored", v, 32'h0);
      rd(A_CNT, v);  chk("R3 counter still held", v, 32'h0042);
      wr(A_AUX, K_CTRL | 32'h3C);
      rd(A_AUX, v); chk("R12 aux readback", v, 32'h3C);
      wr(A_AUX, 32'h5A5A_00FF);
      rd(A_AUX, v); chk("R3 aux wrong key ignored", v, 32'h3C);
      wr(A_CTRL, K_CTRL | 32'h20);
      rd(A_CTRL, v); chk("R7 busy not writable", v, 32'h0);
   endtask

   task automatic t_count_hold();
      logic [31:0] v;
      wr(A_CNT, K_CNT);
      wait_idle();
      wr(A_CTRL, K_CTRL | 32'h80);
      rd(A_CNT, v); chk("R4 start", v, 32'h0);
      repeat (5) @(negedge clk);
      rd(A_CNT, v); chk("R4 five ticks", v, 32'h5);
      wr(A_CTRL, K_CTRL);
      rd(A_CNT, v); chk("R6 stop value", v, 32'h6);
      repeat (8) @(negedge clk);
      rd(A_CNT, v); chk("R6 held", v, 32'h6);
   endtask

   task automatic t_busy();
      logic [31:0] v;
      wr(A_CTRL, K_CTRL | 32'h80);
      wr(A_CNT, K_CNT | 32'h0100);
      rd(A_CNT, v);  chk("R7 loaded", v, 32'h0100);
      rd(A_CTRL, v); chk("R7 busy set", v, 32'hA0);
      @(negedge clk);
      rd(A_CTRL, v); chk("R7 busy second tick", v, 32'hA0);
      rd(A_CNT, v);  chk("R7 counter frozen", v, 32'h0100);
      @(negedge clk);
      rd(A_CTRL, v); chk("R7 busy cleared", v, 32'h80);
      rd(A_CNT, v);  chk("R7 counter still frozen", v, 32'h0100);
      @(negedge clk);
      rd(A_CNT, v);  chk("R4 counting resumes", v, 32'h0101);
      wr(A_CTRL, K_CTRL);
      wait_idle();
      wr(A_CNT, K_CNT | 32'h1000);
      wr(A_CNT, K_CNT | 32'h2000);
      rd(A_CNT, v); chk("R8 write while busy ignored", v, 32'h1000);
      wait_idle();
      wr(A_CNT, K_CNT | 32'h3000);
      rd(A_CNT, v); chk("R8 write after busy accepted", v, 32'h3000);
      wait_idle();
   endtask

   task automatic t_prescale(input logic [2:0] code, input int div);
      logic [31:0] prev, cur;
      int first, second, n;
      first = -1; second = -1; n = 0;
      wr(A_CTRL, K_CTRL | {29'h0, code});
      wr(A_CNT, K_CNT);
      wait_idle();
      wr(A_CTRL, K_CTRL | 32'h80 | {29'h0, code});
      rd(A_CNT, prev);
      while (second < 0 && n < 3 * div + 20) begin
         @(negedge clk);
         n++;
         rd(A_CNT, cur);
         if (cur != prev) begin
            if (first < 0) first = n;
            else second = n;
         end
         prev = cur;
      end
      chk($sformatf("R5 divisor code %0d", code), second - first, div);
      wr(A_CTRL, K_CTRL);
      wait_idle();
   endtask

   // counter three ticks below the wrap, then enabled; returns right after the enabling edge
   task automatic arm_near_wrap();
      wr(A_CTRL, K_CTRL);
      wr(A_CNT, K_CNT | 32'hFFFD);
      wait_idle();
      wr(A_CTRL, K_CTRL | 32'h80);
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      int n;
      n = 0;
      arm_near_wrap();
      while (!rst_req && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk("R9 overflow cycle", n, 3);
      rd(A_CNT, v);  chk("R9 counter wrapped", v, 32'h0);
      rd(A_CTRL, v); chk("R9 flag set enable cleared", v, 32'h10);
      @(negedge clk);
      chk("R9 request one cycle", {31'h0, rst_req}, 32'h0);
      sys_rst_n = 1'b0;
      @(negedge clk);
      sys_rst_n = 1'b1;
      rd(A_CTRL, v); chk("R10 flag survives system reset", v, 32'h10);
      rd(A_AUX, v);  chk("R10 aux cleared by system reset", v, 32'h0);
      wr(A_CTRL, 32'hA5A5_A400);
      rd(A_CTRL, v); chk("R10 wrong key keeps flag", v, 32'h10);
      wr(A_CTRL, K_CTRL | 32'h10);
      rd(A_CTRL, v); chk("R10 writing one keeps flag", v, 32'h10);
      wr(A_CTRL, K_CTRL);
      rd(A_CTRL, v); chk("R10 keyed zero clears flag", v, 32'h0);
      arm_near_wrap();
      repeat (4) @(negedge clk);
      rd(A_CTRL, v); chk("R9 second overflow", v, 32'h10);
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      rd(A_CTRL, v); chk("R10 power-on clears flag", v, 32'h0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] v;
      arm_near_wrap();
      repeat (2) @(negedge clk);
      rd(A_CNT, v); chk("R11 counter at top", v, 32'hFFFF);
      wr(A_CNT, K_CNT | 32'h1234);
      rd(A_CNT, v);  chk("R11 load wins", v, 32'h1234);
      rd(A_CTRL, v); chk("R11 no flag, busy set", v, 32'hA0);
      chk("R11 no request", {31'h0, rst_req}, 32'h0);
      @(negedge clk);
      chk("R11 still no request", {31'h0, rst_req}, 32'h0);
      wr(A_CTRL, K_CTRL);
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_keys();
      t_count_hold();
      t_busy();
      t_prescale(3'd0, 1);
      t_prescale(3'd1, 4);
      t_prescale(3'd3, 32);
      t_prescale(3'd6, 1024);
      t_prescale(3'd7, 4096);
      t_same_cycle();
      t_overflow();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule